// File: doc/BRIEF.md
# Stop-Delimited Bundle Issue Sequencer

This block sits between instruction fetch and a narrow execution back end. It accepts 128-bit instruction bundles, each carrying a 5-bit template and three 41-bit operation slots. It unpacks each bundle into operations and uses the stop markers in the template to find where one explicitly parallel group ends and the next begins. It then hands those operations to a back end that is `W` lanes wide. A group larger than `W` drains over as many cycles as it needs. A group that has no stop at the end of a bundle carries on into the next bundle. Operations from two different groups never leave in the same cycle.

A bundle is held in a one-entry buffer until every operation in it has issued. The input handshake is valid/ready. Ready rises in the cycle in which the last buffered operations issue, so a new bundle can follow without a gap. A stall input freezes issue and the buffer. A synchronous flush discards whatever the buffer still holds.

When the template marks slots 1 and 2 as one long operation, the pair is issued as a single 82-bit operation that occupies one lane.

Top module: `bundle_issue_seq`

## Requirements
- R1: While reset is held and after it is released, with no bundle accepted, `iss_valid` is all zero and `in_ready` is high when `stall` and `flush` are low.
- R2: Bundle bits [4:0] are the template and slot s (s = 0..2) occupies bits [5+41s +: 41]. A normal operation appears on its lane as that slot zero-extended to 82 bits.
- R3: Template bit 0 marks a stop after the last operation of the bundle, bit 1 a stop after slot 0, and bit 2 a stop after slot 1.
- R4: Template bit 3 fuses slots 1 and 2 into one operation with payload {slot2, slot1} and `iss_long` set on its lane. Its stop comes from bit 0, and bit 2 is then ignored. Template bit 4 has no effect.
- R5: Each cycle the block issues up to W pending operations in slot order, packed from lane 0, with `iss_valid` as a thermometer code.
- R6: No operation after a stop issues in the same cycle as the operation carrying that stop. `iss_group_end` is high exactly when the last operation issued in the cycle carries a stop.
- R7: A bundle whose last operation has no stop issues with `iss_group_end` low on its final cycle.
- R8: `in_ready` is high only when the buffer will be empty after this cycle's issue. A bundle offered while `in_ready` is low is not taken and does not disturb issue. An accepted bundle starts issuing in the next cycle.
- R9: While `stall` is high, `iss_valid` is zero and `in_ready` is low. All pending operations issue unchanged once `stall` falls.
- R10: A cycle with `flush` high issues nothing and holds `in_ready` low. From the next cycle the buffer is empty.
- R11: A fused long operation uses one lane, so on a 2-lane back end slot 0 and the long operation issue together when no stop separates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Synchronous discard of the buffered bundle |
| stall | input | 1 | Freeze issue and buffer state |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle will be taken this cycle if offered |
| in_bundle | input | 128 | Template in [4:0], three 41-bit slots above it |
| iss_valid | output | W | Per-lane valid, thermometer from lane 0 |
| iss_long | output | W | Lane carries a fused long operation |
| iss_op | output | W*82 | Lane payloads, lane j at [82j +: 82] |
| iss_group_end | output | 1 | Last issued operation this cycle ends its group |

## Verification
The issue outputs are decoded combinationally from the buffer. A bundle taken at a rising edge therefore shows its first operations in the half cycle after that edge, and each later issue cycle follows one edge after the previous one. `in_ready` and the effects of `stall` and `flush` appear in the same cycle the input is applied, while the buffer clearing caused by a flush is seen one edge later. The bench changes inputs only at falling edges. It samples one time unit after each change, which puts every check between the edge that produced a result and the next edge. It also walks each bundle through exactly the number of issue cycles the template predicts.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;
  localparam int TMPL_W    = 5;
  localparam int SLOT_W    = 41;
  localparam int NUM_SLOTS = 3;
  localparam int BUNDLE_W  = TMPL_W + NUM_SLOTS * SLOT_W;
  localparam int OP_W      = 2 * SLOT_W;
  localparam int MAX_OPS   = NUM_SLOTS;
  localparam int IDX_W     = $clog2(MAX_OPS + 1);

  typedef logic [OP_W-1:0] op_word_t;

  typedef struct packed {
    logic stop_a;    // stop after slot 0
    logic stop_b;    // stop after slot 1
    logic stop_end;  // stop after the final operation
    logic fuse12;    // slots 1 and 2 form one operation
  } tmpl_info_t;

  function automatic tmpl_info_t decode_tmpl(input logic [3:0] ctl);
    tmpl_info_t r;
    r.stop_end = ctl[0];
    r.stop_a   = ctl[1];
    r.stop_b   = ctl[2] & ~ctl[3];
    r.fuse12   = ctl[3];
    return r;
  endfunction
endpackage

// File: rtl/bsq_rst_sync.sv
`timescale 1ns/1ps
module bsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsq_unpack.sv
`timescale 1ns/1ps
module bsq_unpack
  import bsq_pkg::*;
(
  input  logic [BUNDLE_W-1:0]            bundle,
  output op_word_t [MAX_OPS-1:0]         op_data,
  output logic [MAX_OPS-1:0]             op_long,
  output logic [MAX_OPS-1:0]             op_stop,
  output logic [IDX_W-1:0]               op_cnt
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot;
  tmpl_info_t                       info;
  logic                             kind_unused;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot[s] = bundle[TMPL_W + s*SLOT_W +: SLOT_W];
  end

  assign info        = decode_tmpl(bundle[3:0]);
  assign kind_unused = bundle[TMPL_W-1];

  always_comb begin
    op_data    = '0;
    op_long    = '0;
    op_stop    = '0;
    op_data[0] = {{(OP_W-SLOT_W){1'b0}}, slot[0]};
    op_stop[0] = info.stop_a;
    if (info.fuse12) begin
      op_data[1] = {slot[2], slot[1]};
      op_long[1] = 1'b1;
      op_stop[1] = info.stop_end;
      op_cnt     = IDX_W'(2);
    end else begin
      op_data[1] = {{(OP_W-SLOT_W){1'b0}}, slot[1]};
      op_stop[1] = info.stop_b;
      op_data[2] = {{(OP_W-SLOT_W){1'b0}}, slot[2]};
      op_stop[2] = info.stop_end;
      op_cnt     = IDX_W'(3);
    end
  end
endmodule

// File: rtl/bsq_select.sv
`timescale 1ns/1ps
module bsq_select
  import bsq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic                      en,
  input  logic [IDX_W-1:0]          head,
  input  logic [IDX_W-1:0]          cnt,
  input  logic [MAX_OPS-1:0]        op_stop,
  output logic [W-1:0]              lane_vld,
  output logic [W-1:0][IDX_W-1:0]   lane_idx,
  output logic [IDX_W-1:0]          take,
  output logic                      grp_end
);
  logic blocked;
  int   pos;

  always_comb begin
    lane_vld = '0;
    lane_idx = '0;
    take     = '0;
    grp_end  = 1'b0;
    blocked  = ~en;
    pos      = 0;
    for (int j = 0; j < W; j++) begin
      pos = int'(head) + j;
      if (!blocked && pos < int'(cnt)) begin
        lane_vld[j] = 1'b1;
        lane_idx[j] = IDX_W'(pos);
        take        = take + 1'b1;
        if (op_stop[IDX_W'(pos)]) begin
          blocked = 1'b1;
          grp_end = 1'b1;
        end
      end else begin
        blocked = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bundle_issue_seq.sv
`timescale 1ns/1ps
module bundle_issue_seq
  import bsq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 stall,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BUNDLE_W-1:0]  in_bundle,
  output logic [W-1:0]         iss_valid,
  output logic [W-1:0]         iss_long,
  output logic [W*OP_W-1:0]    iss_op,
  output logic                 iss_group_end
);
  logic rst_int_n;

  op_word_t [MAX_OPS-1:0] dec_op;
  logic [MAX_OPS-1:0]     dec_long, dec_stop;
  logic [IDX_W-1:0]       dec_cnt;

  op_word_t [MAX_OPS-1:0] buf_op_q;
  logic [MAX_OPS-1:0]     buf_long_q, buf_stop_q;
  logic [IDX_W-1:0]       head_q, head_nxt, cnt_q, cnt_nxt;

  logic [W-1:0]            lane_vld;
  logic [W-1:0][IDX_W-1:0] lane_idx;
  logic [IDX_W-1:0]        take, head_adv;
  logic                    grp_end, issue_en, accept, load_en;

  bsq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  bsq_unpack u_unpack (
    .bundle  (in_bundle),
    .op_data (dec_op),
    .op_long (dec_long),
    .op_stop (dec_stop),
    .op_cnt  (dec_cnt)
  );

  bsq_select #(.W(W)) u_select (
    .en       (issue_en),
    .head     (head_q),
    .cnt      (cnt_q),
    .op_stop  (buf_stop_q),
    .lane_vld (lane_vld),
    .lane_idx (lane_idx),
    .take     (take),
    .grp_end  (grp_end)
  );

  // next-state logic
  always_comb begin
    issue_en = ~stall & ~flush;
    head_adv = head_q + take;
    in_ready = issue_en & (head_adv == cnt_q);
    accept   = in_valid & in_ready;
    load_en  = 1'b0;
    head_nxt = head_adv;
    cnt_nxt  = cnt_q;
    if (flush) begin
      head_nxt = '0;
      cnt_nxt  = '0;
    end else if (accept) begin
      head_nxt = '0;
      cnt_nxt  = dec_cnt;
      load_en  = 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  // payload registers, no reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      buf_op_q   <= dec_op;
      buf_long_q <= dec_long;
      buf_stop_q <= dec_stop;
    end
  end

  for (genvar j = 0; j < W; j++) begin : g_lane
    assign iss_valid[j]              = lane_vld[j];
    assign iss_long[j]               = lane_vld[j] & buf_long_q[lane_idx[j]];
    assign iss_op[j*OP_W +: OP_W]    = lane_vld[j] ? buf_op_q[lane_idx[j]] : '0;
  end

  assign iss_group_end = grp_end;
endmodule

// File: rtl/bsq_checker.sv
`timescale 1ns/1ps
module bsq_checker #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stall,
  input logic         flush,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] iss_valid,
  input logic         iss_group_end
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (iss_valid == '0)
        else $error("lanes active during reset");
    end
  end

  p_lanes_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_valid + 1'b1) & iss_valid) == '0);

  p_end_has_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_group_end |-> iss_valid[0]);

  p_accept_issues_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (stall || flush || iss_valid[0]));

  p_busy_issues_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !stall && !flush) |-> iss_valid[0]);

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (iss_valid == '0 && !in_ready));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (iss_valid == '0));
endmodule

bind bundle_issue_seq bsq_checker #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .flush         (flush),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .iss_valid     (iss_valid),
  .iss_group_end (iss_group_end)
);

// File: tb/bundle_issue_seq_test.sv
`timescale 1ns/1ps
module bundle_issue_seq_test;
  localparam int W    = 2;
  localparam int OPW  = 82;
  localparam int NVEC = 12;

  // {tmpl[4:0], cycles[1:0], n0[1:0], e0, n1[1:0], e1, n2[1:0], e2}
  localparam logic [15:0] VEC [NVEC] = '{
    {5'h01, 2'd2, 2'd2, 1'b0, 2'd1, 1'b1, 2'd0, 1'b0},  // R3 end stop
    {5'h00, 2'd2, 2'd2, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0},  // R7 no stop
    {5'h03, 2'd2, 2'd1, 1'b1, 2'd2, 1'b1, 2'd0, 1'b0},  // R3 stop after slot 0
    {5'h05, 2'd2, 2'd2, 1'b1, 2'd1, 1'b1, 2'd0, 1'b0},  // R3 stop after slot 1
    {5'h07, 2'd3, 2'd1, 1'b1, 2'd1, 1'b1, 2'd1, 1'b1},  // R3 every stop
    {5'h02, 2'd2, 2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0},  // R7 open tail
    {5'h08, 2'd1, 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},  // R11 fused in one lane
    {5'h09, 2'd1, 2'd2, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0},  // R11 fused with stop
    {5'h0A, 2'd2, 2'd1, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0},  // R4 fused, open tail
    {5'h0B, 2'd2, 2'd1, 1'b1, 2'd1, 1'b1, 2'd0, 1'b0},  // R4 fused after stop
    {5'h0C, 2'd1, 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},  // R4 bit 2 ignored
    {5'h11, 2'd2, 2'd2, 1'b0, 2'd1, 1'b1, 2'd0, 1'b0}   // R4 bit 4 ignored
  };

  logic             clk, rst_n, flush, stall, in_valid;
  logic             in_ready;
  logic [127:0]     in_bundle;
  logic [W-1:0]     iss_valid, iss_long;
  logic [W*OPW-1:0] iss_op;
  logic             iss_group_end;
  int               nchk, nerr;

  bundle_issue_seq #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .stall(stall),
    .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
    .iss_valid(iss_valid), .iss_long(iss_long), .iss_op(iss_op),
    .iss_group_end(iss_group_end)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [40:0] slotv(int e, int s);
    return {8'(e), 4'(s), 29'h0A5A5A5};
  endfunction

  function automatic logic [127:0] mk_bundle(int e, int t);
    return {slotv(e, 2), slotv(e, 1), slotv(e, 0), 5'(t)};
  endfunction

  function automatic logic [81:0] model_op(int e, int t, int k);
    logic fused = t[3];
    if (k == 0)          return {41'b0, slotv(e, 0)};
    if (fused && k == 1) return {slotv(e, 2), slotv(e, 1)};
    return {41'b0, slotv(e, k)};
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic check_cycle(input int e, input int t, input int n, input bit en,
                             inout int opi);
    chk("R5 lane valid", 128'(iss_valid), 128'((1 << n) - 1));
    chk("R6 group end", 128'(iss_group_end), 128'(en));
    for (int j = 0; j < n; j++) begin
      chk("R2 lane payload", 128'(iss_op[j*OPW +: OPW]), 128'(model_op(e, t, opi)));
      chk("R4 long flag", 128'(iss_long[j]), 128'(t[3] && opi == 1));
      opi++;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0;
    rst_n = 1'b0; flush = 1'b0; stall = 1'b0; in_valid = 1'b0; in_bundle = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 idle in reset", 128'(iss_valid), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 ready after reset", 128'(in_ready), 128'(1));
    chk("R1 no issue after reset", 128'(iss_valid), 128'(0));

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int t, ncyc, opi;
      int n [3];
      bit en [3];
      t = int'(VEC[v][15:11]); ncyc = int'(VEC[v][10:9]);
      n[0] = int'(VEC[v][8:7]); en[0] = VEC[v][6];
      n[1] = int'(VEC[v][5:4]); en[1] = VEC[v][3];
      n[2] = int'(VEC[v][2:1]); en[2] = VEC[v][0];
      opi = 0;
      @(negedge clk);
      in_valid = 1'b1; in_bundle = mk_bundle(v, t);
      #1;
      chk("R8 ready when empty", 128'(in_ready), 128'(1));
      chk("R8 idle before load", 128'(iss_valid), 128'(0));
      for (int c = 0; c < ncyc; c++) begin
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check_cycle(v, t, n[c], en[c], opi);
        chk("R8 ready on last issue", 128'(in_ready), 128'(c == ncyc - 1));
      end
    end

    // R8: bundle offered while busy is held off, then taken back to back
    @(negedge clk);
    in_valid = 1'b1; in_bundle = mk_bundle(20, 5'h07);
    @(negedge clk);
    in_bundle = mk_bundle(21, 5'h01);
    #1;
    chk("R8 busy ready low", 128'(in_ready), 128'(0));
    chk("R8 first op of held bundle", 128'(iss_op[0 +: OPW]), 128'(model_op(20, 7, 0)));
    @(negedge clk);
    #1;
    chk("R8 offer ignored", 128'(iss_op[0 +: OPW]), 128'(model_op(20, 7, 1)));
    @(negedge clk);
    #1;
    chk("R8 last op, ready", 128'(in_ready), 128'(1));
    chk("R8 last op payload", 128'(iss_op[0 +: OPW]), 128'(model_op(20, 7, 2)));
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R8 next bundle lanes", 128'(iss_valid), 128'(3));
    chk("R8 next bundle lane1", 128'(iss_op[OPW +: OPW]), 128'(model_op(21, 1, 1)));

    // R9: stall freezes and resumes
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_bundle = mk_bundle(22, 5'h00);
    @(negedge clk);
    in_valid = 1'b0; stall = 1'b1;
    #1;
    chk("R9 stall no issue", 128'(iss_valid), 128'(0));
    chk("R9 stall ready low", 128'(in_ready), 128'(0));
    @(negedge clk);
    #1;
    chk("R9 still frozen", 128'(iss_valid), 128'(0));
    stall = 1'b0;
    #1;
    chk("R9 resume lanes", 128'(iss_valid), 128'(3));
    chk("R9 resume op0", 128'(iss_op[0 +: OPW]), 128'(model_op(22, 0, 0)));
    @(negedge clk);
    #1;
    chk("R9 resume op2", 128'(iss_op[0 +: OPW]), 128'(model_op(22, 0, 2)));
    chk("R9 drained ready", 128'(in_ready), 128'(1));

    // R10: flush discards
    @(negedge clk);
    in_valid = 1'b1; in_bundle = mk_bundle(23, 5'h00);
    @(negedge clk);
    in_valid = 1'b0; flush = 1'b1;
    #1;
    chk("R10 flush ready low", 128'(in_ready), 128'(0));
    chk("R10 flush no issue", 128'(iss_valid), 128'(0));
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk("R10 empty after flush", 128'(iss_valid), 128'(0));
    chk("R10 ready after flush", 128'(in_ready), 128'(1));

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule